// File: doc/BRIEF.md
# RNG Health-Check Status Controller

This block is the status and control front end of a hardware random number source. It watches the raw entropy bit stream for runs of identical bits at two lengths, watches the conditioned output words for a repeat of the previous word, and collects these results together with pulses from the external statistical window tests into a sticky status register. Software acknowledges status by writing ones. The same register carries a ready flag that marks a captured output word as available to be read.

Output words arrive on a valid/ready stream. `word_ready` is high only while the generator is enabled and the ready flag is clear. A word transfers on any rising clock edge where `word_valid` and `word_ready` are both high. That transfer sets the ready flag, which lowers `word_ready` until software clears the flag. The source must hold `word_valid` and `word_data` steady while it waits. A level interrupt reports every status source whose mask bit is set.

Top module: `rng_health_ctrl`

## Requirements
- R1: After reset, the status register, the control register and the data word all read 0, and both `irq` and `word_ready` are low.
- R2: Reads return the data word at offset 0x00, the status at offset 0x10 and the control at offset 0x14. Control stores only bit 10 (generator enable) and bits 7..1 (interrupt masks). All other control bits read 0.
- R3: Writing to the status register clears each bit whose written value is 1 and leaves each bit whose written value is 0. When a set event and a clear hit the same bit in the same cycle, the set wins.
- R4: `word_ready` equals enable AND NOT status bit 0. A transfer sets status bit 0 and makes the word readable at offset 0x00. A word offered while `word_ready` is low is not taken.
- R5: Status bit 5 sets when 34 consecutive raw bits of the same value have been seen.
- R6: Status bit 3 sets when 48 consecutive raw bits of the same value have been seen.
- R7: A change of raw bit value restarts the run count at 1. The count saturates, so one run raises each run flag at most once, even if the flag is cleared while the run continues.
- R8: Status bit 2 sets when a transferred word equals the word transferred before it. The first word after reset or after enable is not compared.
- R9: Pulses on the window-test inputs set status bit 7 (monobit), bit 6 (poker), bit 4 (runs) and bit 1 (shutdown overflow).
- R10: `irq` is the OR over k = 7..1 of status bit k AND control bit k.
- R11: While control bit 10 is 0, no status bit sets, `word_ready` is low, and both the run history and the previous word are forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| raw_valid | input | 1 | Raw bit strobe |
| raw_bit | input | 1 | Raw entropy bit |
| word_valid | input | 1 | Output word offered |
| word_data | input | DATA_W | Output word |
| word_ready | output | 1 | Block can take a word |
| win_mono_fail | input | 1 | Monobit window test failure pulse |
| win_poker_fail | input | 1 | Poker window test failure pulse |
| win_runs_fail | input | 1 | Runs window test failure pulse |
| osc_shutdown | input | 1 | Oscillator shutdown overflow pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit words, an 8-bit offset, and run thresholds of 34 and 48. With these values the directed runs of 33, 34, 47 and 48 bits land on both threshold edges. The random run lengths of 1 to 60 straddle both limits, so every run either trips both flags, trips only the shorter one, or trips neither. Random words repeat about a quarter of the time, which exercises the repeat comparison alongside the skip of the first word after enable.

// File: rtl/rng_hc_pkg.sv
package rng_hc_pkg;
  // register byte offsets
  localparam int unsigned OFS_DATA   = 'h00;
  localparam int unsigned OFS_STATUS = 'h10;
  localparam int unsigned OFS_CTRL   = 'h14;

  // status bit positions (software decodes these)
  localparam int unsigned ST_MONO   = 7;
  localparam int unsigned ST_POKER  = 6;
  localparam int unsigned ST_LONG   = 5;
  localparam int unsigned ST_RUNS   = 4;
  localparam int unsigned ST_NOISE  = 3;
  localparam int unsigned ST_STUCK  = 2;
  localparam int unsigned ST_SHUT   = 1;
  localparam int unsigned ST_READY  = 0;
  localparam int unsigned ST_W      = 8;

  localparam int unsigned CTRL_EN   = 10;

  typedef logic [ST_W-1:0] status_t;
endpackage

// File: rtl/rng_run_det.sv
module rng_run_det #(
  parameter int unsigned THRESH = 34,
  localparam int unsigned CW = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_in,
  output logic hit
);
  logic [CW-1:0] cnt_q;
  logic          last_q;
  logic          same;

  assign same = (cnt_q != '0) && (bit_in == last_q);
  assign hit  = bit_vld && !clr && same && (cnt_q == CW'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
    end else if (bit_vld) begin
      last_q <= bit_in;
      if (!same)
        cnt_q <= CW'(1);
      else if (cnt_q != CW'(THRESH))
        cnt_q <= cnt_q + CW'(1);
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(THRESH));
  // R7
  hit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/rng_word_cap.sv
module rng_word_cap #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              accept,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] data_q,
  output logic              stuck
);
  logic have_prev_q;

  assign stuck = accept && have_prev_q && (word_in == data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q      <= '0;
      have_prev_q <= 1'b0;
    end else begin
      if (accept)
        data_q <= word_in;
      if (clr)
        have_prev_q <= 1'b0;
      else if (accept)
        have_prev_q <= 1'b1;
    end
  end

  // R4
  word_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> data_q == $past(word_in));
endmodule

// File: rtl/rng_hc_regs.sv
module rng_hc_regs
  import rng_hc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  status_t           set_evt,
  input  logic [DATA_W-1:0] data_word,
  output logic [DATA_W-1:0] rdata,
  output status_t           status,
  output logic              en,
  output logic              irq
);
  logic [ST_W-1:1] mask_q;
  logic            wr_sts, wr_ctl;
  status_t         clr_bits;
  logic            unused_wbits;

  assign wr_sts   = wr && (addr == ADDR_W'(OFS_STATUS));
  assign wr_ctl   = wr && (addr == ADDR_W'(OFS_CTRL));
  assign clr_bits = wr_sts ? wdata[ST_W-1:0] : '0;
  assign unused_wbits = ^{wdata[DATA_W-1:CTRL_EN+1], wdata[CTRL_EN-1:ST_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask_q <= '0;
      en     <= 1'b0;
    end else begin
      status <= (status & ~clr_bits) | set_evt;
      if (wr_ctl) begin
        en     <= wdata[CTRL_EN];
        mask_q <= wdata[ST_W-1:1];
      end
    end
  end

  assign irq = |(status[ST_W-1:1] & mask_q);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFS_DATA))
      rdata = data_word;
    else if (addr == ADDR_W'(OFS_STATUS))
      rdata[ST_W-1:0] = status;
    else if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata[CTRL_EN]  = en;
      rdata[ST_W-1:1] = mask_q;
    end
  end

  // R3
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[ST_READY] && !set_evt[ST_READY]) |=> !status[ST_READY]);
  // R11
  set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & ~$past(status))) |-> $past(en));
endmodule

// File: rtl/rng_health_ctrl.sv
module rng_health_ctrl
  import rng_hc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned LONG_RUN_LEN  = 34,
  parameter int unsigned NOISE_RUN_LEN = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              raw_valid,
  input  logic              raw_bit,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  output logic              word_ready,
  input  logic              win_mono_fail,
  input  logic              win_poker_fail,
  input  logic              win_runs_fail,
  input  logic              osc_shutdown,
  output logic              irq
);
  localparam int unsigned N_DET = 2;
  localparam int unsigned DET_THR [N_DET] = '{LONG_RUN_LEN, NOISE_RUN_LEN};

  logic              en;
  status_t           status, set_evt;
  logic [N_DET-1:0]  run_hit;
  logic              accept, stuck;
  logic [DATA_W-1:0] data_q;

  assign word_ready = en && !status[ST_READY];
  assign accept     = word_valid && word_ready;

  for (genvar i = 0; i < N_DET; i++) begin : g_run
    rng_run_det #(.THRESH(DET_THR[i])) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!en),
      .bit_vld(raw_valid),
      .bit_in (raw_bit),
      .hit    (run_hit[i])
    );
  end

  rng_word_cap #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!en),
    .accept (accept),
    .word_in(word_data),
    .data_q (data_q),
    .stuck  (stuck)
  );

  always_comb begin
    set_evt = '0;
    if (en) begin
      set_evt[ST_MONO]  = win_mono_fail;
      set_evt[ST_POKER] = win_poker_fail;
      set_evt[ST_LONG]  = run_hit[0];
      set_evt[ST_RUNS]  = win_runs_fail;
      set_evt[ST_NOISE] = run_hit[1];
      set_evt[ST_STUCK] = stuck;
      set_evt[ST_SHUT]  = osc_shutdown;
      set_evt[ST_READY] = accept;
    end
  end

  rng_hc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .set_evt  (set_evt),
    .data_word(data_q),
    .rdata    (reg_rdata),
    .status   (status),
    .en       (en),
    .irq      (irq)
  );

  // R4
  accept_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> status[ST_READY] && !word_ready);
  // R11
  idle_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_wr) |=> !word_ready);
endmodule

// File: tb/sim_rng_health_ctrl.sv
module sim_rng_health_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        raw_valid = 1'b0, raw_bit = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready, irq;
  logic        mono = 1'b0, poker = 1'b0, runs = 1'b0, shut = 1'b0;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  rng_health_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .raw_valid(raw_valid),
    .raw_bit(raw_bit), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .win_mono_fail(mono), .win_poker_fail(poker),
    .win_runs_fail(runs), .osc_shutdown(shut), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic bits(logic b, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raw_valid = 1'b1; raw_bit = b;
    end
    @(negedge clk);
    raw_valid = 1'b0;
  endtask

  task automatic push(logic [31:0] w);
    @(negedge clk);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  function automatic logic [31:0] exp_words(logic st, logic rdy);
    return {29'b0, st, 1'b0, rdy};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    logic have_prev, cur;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h10, d); chk("R1 status", d, 0);
    rd(8'h14, d); chk("R1 ctrl", d, 0);
    rd(8'h00, d); chk("R1 data", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 word_ready", word_ready, 0);

    // R2 control field storage
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R2 ctrl readback", d, 32'h0000_04FE);
    chk("R4 ready after enable", word_ready, 1);

    // R4 and R8 first word
    push(32'hA5A5_0001);
    rd(8'h10, d); chk("R8 first word not compared", d, 32'h1);
    rd(8'h00, d); chk("R4 data word", d, 32'hA5A5_0001);
    chk("R4 ready low when full", word_ready, 0);
    push(32'h0000_1234);
    rd(8'h00, d); chk("R4 back-pressure keeps word", d, 32'hA5A5_0001);

    // R3 write-one-to-clear
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R3 zero write no effect", d, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, d); chk("R3 clear ready", d, 32'h0);
    chk("R4 ready after clear", word_ready, 1);

    // R8 repeated word
    push(32'hA5A5_0001);
    rd(8'h10, d); chk("R8 stuck set", d, 32'h5);
    chk("R10 irq on stuck", irq, 1);
    wr(8'h10, 32'h5);

    // R5 R6 threshold edges
    bits(1'b0, 33);
    rd(8'h10, d); chk("R5 33 bits no flag", d, 0);
    bits(1'b0, 1);
    rd(8'h10, d); chk("R5 34 bits long flag", d, 32'h20);
    bits(1'b0, 13);
    rd(8'h10, d); chk("R6 47 bits no noise", d, 32'h20);
    bits(1'b0, 1);
    rd(8'h10, d); chk("R6 48 bits noise", d, 32'h28);
    wr(8'h10, 32'h28);

    // R7 restart on change
    bits(1'b1, 33); bits(1'b0, 1); bits(1'b1, 33);
    rd(8'h10, d); chk("R7 restart at change", d, 0);
    // R7 saturation: one flag per run
    bits(1'b0, 50);
    rd(8'h10, d); chk("R7 run flags", d, 32'h28);
    wr(8'h10, 32'h28);
    bits(1'b0, 50);
    rd(8'h10, d); chk("R7 no re-raise in same run", d, 0);

    // R9 window test pulses
    @(negedge clk); mono = 1; @(negedge clk); mono = 0;
    rd(8'h10, d); chk("R9 monobit", d, 32'h80); wr(8'h10, 32'hFF);
    @(negedge clk); poker = 1; @(negedge clk); poker = 0;
    rd(8'h10, d); chk("R9 poker", d, 32'h40); wr(8'h10, 32'hFF);
    @(negedge clk); runs = 1; @(negedge clk); runs = 0;
    rd(8'h10, d); chk("R9 runs", d, 32'h10); wr(8'h10, 32'hFF);
    @(negedge clk); shut = 1; @(negedge clk); shut = 0;
    rd(8'h10, d); chk("R9 shutdown", d, 32'h02); wr(8'h10, 32'hFF);

    // R3 set wins over clear
    @(negedge clk);
    mono = 1; reg_wr = 1; reg_addr = 8'h10; reg_wdata = 32'h80;
    @(negedge clk);
    mono = 0; reg_wr = 0;
    rd(8'h10, d); chk("R3 set beats clear", d, 32'h80);
    wr(8'h10, 32'hFF);

    // R10 masking
    wr(8'h14, 32'h480);
    @(negedge clk); poker = 1; @(negedge clk); poker = 0;
    chk("R10 masked source", irq, 0);
    @(negedge clk); mono = 1; @(negedge clk); mono = 0;
    chk("R10 unmasked source", irq, 1);
    wr(8'h10, 32'h80);
    chk("R10 irq drops", irq, 0);
    wr(8'h10, 32'hFF);

    // R11 disabled
    wr(8'h14, 32'h0FE);
    @(negedge clk); mono = 1; shut = 1; @(negedge clk); mono = 0; shut = 0;
    bits(1'b1, 60);
    push(32'h0BAD_F00D);
    rd(8'h10, d); chk("R11 nothing sets", d, 0);
    chk("R11 word_ready low", word_ready, 0);
    rd(8'h00, d); chk("R11 word not taken", d, 32'hA5A5_0001);
    wr(8'h14, 32'h4FE);
    push(32'hA5A5_0001);
    rd(8'h10, d); chk("R11 previous word forgotten", d, 32'h1);
    wr(8'h10, 32'hFF);

    // R5 R6 random run lengths
    cur = 1'b0;
    for (int r = 0; r < 40; r++) begin
      int len;
      len = int'($urandom % 60) + 1;
      cur = ~cur;
      bits(cur, len);
      rd(8'h10, d);
      chk($sformatf("R5 R6 run len %0d", len), d,
          {26'b0, len >= 34, 1'b0, len >= 48, 3'b0});
      wr(8'h10, 32'h28);
    end

    // R8 random words
    have_prev = 1'b1; prev = 32'hA5A5_0001;
    for (int k = 0; k < 30; k++) begin
      logic [31:0] w;
      w = ($urandom % 4 == 0) ? prev : $urandom;
      push(w);
      rd(8'h10, d);
      chk("R8 random word", d, exp_words(have_prev && w == prev, 1'b1));
      rd(8'h00, d); chk("R4 random word data", d, w);
      prev = w;
      wr(8'h10, 32'h5);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule